// File: doc/BRIEF.md
# Serial-Addressed Attenuation Code Register

This block is the digital front end of a 7-bit step attenuator. A host drives three wires into it: serial data, a serial clock and a latch strobe. While the strobe is low, every rising edge of the serial clock pushes one data bit into a 16-bit frame register. The low byte of the frame carries the attenuation code and the high byte carries a target address. When the strobe is raised, the frame is compared against three strapped address pins. A frame that matches, is complete and is well formed replaces the held attenuation code. Any other frame leaves the code as it was.

The code drives the attenuator's switch array directly. Bit k of the code switches in 0.25·2^k dB, so the code value equals four times the attenuation in dB. The three serial wires are treated as asynchronous. Each one passes through a two-flop synchronizer into a faster system clock before its edges are detected. After a power-up reset the code is the maximum attenuation, and it stays there until a valid frame is latched. A one-cycle reject pulse marks each complete frame that was refused.

Top module: `atten_ser_ctrl`

## Requirements
- R1: After reset, `atten_code` is 0x7F (31.75 dB) and `frame_reject` is low, and both stay that way until a frame is latched.
- R2: Frame bits arrive least significant bit first, and the attenuation byte comes before the address byte. After 16 shifts, frame bits 6:0 form the new code and frame bit 7 is the guard bit. Code weights are 0.25, 0.5, 1, 2, 4, 8 and 16 dB for bits 0 to 6, so 18.25 dB is code 73 (0b1001001).
- R3: Only frame bits 10:8 are compared with `addr_strap[2:0]`. Frame bits 15:11 have no effect on acceptance or on the code.
- R4: A complete frame whose address field differs from the strap leaves `atten_code` unchanged and raises `frame_reject` for exactly one system clock cycle.
- R5: A complete, matching frame whose guard bit (frame bit 7) is 1 leaves `atten_code` unchanged and raises the one-cycle `frame_reject` pulse.
- R6: `atten_code` does not change while bits are being shifted. It changes only in response to a rising edge of `ser_latch`, and the new value is visible within 4 system clock cycles of that edge.
- R7: When fewer than 16 serial clock rising edges have been seen since `ser_latch` last fell (or since reset), the frame is discarded: the code does not change and no reject pulse is raised.
- R8: When more than 16 bits are shifted before the latch, only the last 16 bits make up the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset, stands for power-up |
| ser_data | input | 1 | Serial frame data, asynchronous |
| ser_clk | input | 1 | Serial shift clock, rising edge active, asynchronous |
| ser_latch | input | 1 | Latch strobe: low while shifting, rising edge commits |
| addr_strap | input | 3 | Static address of this device |
| atten_code | output | 7 | Held attenuation code, 0.25 dB per LSB |
| frame_reject | output | 1 | One-cycle pulse for a refused complete frame |

## Verification
The assertions check the cycle-level rules on every cycle. The code may change only in the cycle after a detected latch edge, and only when a full frame was present. A reject pulse lasts a single cycle and never coincides with a code update. The value just after reset is also checked. Whether the right bits land in the right code positions, whether the address compare ignores the high byte, and how short and overlong frames are handled depend on the serial bit order. Only the bench scenarios can show these. They sweep all 128 codes and every pairing of strap and frame address.

// File: rtl/atten_pkg.sv
`timescale 1ns/1ps
package atten_pkg;
  // Default geometry of the serial frame and the attenuation code.
  localparam int ATT_W_DEF  = 7;
  localparam int WORD_W_DEF = 8;
  localparam int ADDR_W_DEF = 3;
  localparam int SYNC_DEF   = 2;

  // Index of each synchronized serial wire inside the synchronizer bank.
  typedef enum int {
    WIRE_DATA  = 0,
    WIRE_CLK   = 1,
    WIRE_LATCH = 2
  } ser_wire_e;

  localparam int N_WIRES = 3;
endpackage

// File: rtl/sig_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer with edge detection on the synchronized level.
module sig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
  assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/frame_shifter.sv
`timescale 1ns/1ps
// LSB-first frame register with a saturating count of shifted bits.
module frame_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_in,
  input  logic               shift_en,
  input  logic               clear_cnt,
  output logic [FRAME_W-1:0] frame,
  output logic               full
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      cnt  <= '0;
    end else begin
      if (shift_en && !clear_cnt) begin
        // New bit enters at the top; the first bit ends up at bit 0.
        sreg <= {bit_in, sreg[FRAME_W-1:1]};
      end
      if (clear_cnt) begin
        cnt <= '0;
      end else if (shift_en && cnt != CNT_TOP) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign frame = sreg;
  assign full  = (cnt == CNT_TOP);
endmodule

// File: rtl/frame_commit.sv
`timescale 1ns/1ps
// Decides on a latch edge whether the frame replaces the held code.
module frame_commit #(
  parameter int ATT_W  = 7,
  parameter int WORD_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic                full,
  input  logic [2*WORD_W-1:0] frame,
  input  logic [ADDR_W-1:0]   strap,
  output logic [ATT_W-1:0]    code,
  output logic                reject
);
  localparam logic [ATT_W-1:0] CODE_MAX = {ATT_W{1'b1}};

  logic [WORD_W-1:0] att_word;
  logic [ADDR_W-1:0] addr_field;
  logic              guard_set;
  logic              addr_hit;
  logic              accept;
  logic              refuse;

  always_comb begin
    att_word   = frame[WORD_W-1:0];
    addr_field = frame[WORD_W +: ADDR_W];
    guard_set  = |att_word[WORD_W-1:ATT_W];
    addr_hit   = (addr_field == strap);
    accept     = take & full & addr_hit & ~guard_set;
    refuse     = take & full & ~(addr_hit & ~guard_set);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code   <= CODE_MAX;
      reject <= 1'b0;
    end else begin
      if (accept) begin
        code <= att_word[ATT_W-1:0];
      end
      reject <= refuse;
    end
  end
endmodule

// File: rtl/atten_ser_ctrl.sv
`timescale 1ns/1ps
module atten_ser_ctrl
  import atten_pkg::*;
#(
  parameter int ATT_W  = ATT_W_DEF,
  parameter int WORD_W = WORD_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int SYNC_N = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              ser_latch,
  input  logic [ADDR_W-1:0] addr_strap,
  output logic [ATT_W-1:0]  atten_code,
  output logic              frame_reject
);
  localparam int FRAME_W = 2 * WORD_W;

  logic [N_WIRES-1:0] raw_w;
  logic [N_WIRES-1:0] lvl_w;
  logic [N_WIRES-1:0] rise_w;
  logic [N_WIRES-1:0] fall_w;

  assign raw_w[WIRE_DATA]  = ser_data;
  assign raw_w[WIRE_CLK]   = ser_clk;
  assign raw_w[WIRE_LATCH] = ser_latch;

  for (genvar g = 0; g < N_WIRES; g++) begin : g_sync
    sig_sync #(.STAGES(SYNC_N)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .din   (raw_w[g]),
      .level (lvl_w[g]),
      .rise  (rise_w[g]),
      .fall  (fall_w[g])
    );
  end

  logic               le_level;
  logic               le_rise;
  logic               le_fall;
  logic               shift_en;
  logic               frame_full;
  logic [FRAME_W-1:0] frame;

  assign le_level = lvl_w[WIRE_LATCH];
  assign le_rise  = rise_w[WIRE_LATCH];
  assign le_fall  = fall_w[WIRE_LATCH];
  assign shift_en = rise_w[WIRE_CLK] & ~le_level;

  frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (lvl_w[WIRE_DATA]),
    .shift_en  (shift_en),
    .clear_cnt (le_fall),
    .frame     (frame),
    .full      (frame_full)
  );

  // The strap pins are static board straps and are used unsynchronized.
  frame_commit #(.ATT_W(ATT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_commit (
    .clk    (clk),
    .rst    (rst),
    .take   (le_rise),
    .full   (frame_full),
    .frame  (frame),
    .strap  (addr_strap),
    .code   (atten_code),
    .reject (frame_reject)
  );
endmodule

// File: rtl/atten_ser_ctrl_chk.sv
`timescale 1ns/1ps
module atten_ser_ctrl_chk #(
  parameter int ATT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [ATT_W-1:0] atten_code,
  input logic             frame_reject,
  input logic             le_rise,
  input logic             frame_full
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: code sits at maximum right after reset
  always @(posedge clk) begin
    if (rst_d && !rst) begin
      assert_reset_max_R1: assert (atten_code == {ATT_W{1'b1}});
    end
  end

  // R6: the code moves only after a detected latch edge
  assert_change_on_latch_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(atten_code) |-> $past(le_rise));

  // R7: the code moves only when a full frame was present
  assert_change_needs_full_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(atten_code) |-> $past(frame_full));

  // R4: reject is a single-cycle pulse
  assert_reject_single_R4: assert property (@(posedge clk) disable iff (rst)
    frame_reject |=> !frame_reject);

  // R5: a refused frame never updates the code
  assert_reject_keeps_code_R5: assert property (@(posedge clk) disable iff (rst)
    frame_reject |-> $stable(atten_code));
endmodule

bind atten_ser_ctrl atten_ser_ctrl_chk #(.ATT_W(ATT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .atten_code   (atten_code),
  .frame_reject (frame_reject),
  .le_rise      (le_rise),
  .frame_full   (frame_full)
);

// File: tb/sim_atten_ser_ctrl.sv
`timescale 1ns/1ps
module sim_atten_ser_ctrl;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_data = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_latch = 1'b0;
  logic [2:0] addr_strap = 3'd0;
  logic [6:0] atten_code;
  logic       frame_reject;

  int total = 0;
  int bad = 0;
  int rej_cnt = 0;
  logic [6:0] cur_exp = 7'h7F;

  always #2.5 clk = ~clk;

  atten_ser_ctrl u0 (
    .clk          (clk),
    .rst          (rst),
    .ser_data     (ser_data),
    .ser_clk      (ser_clk),
    .ser_latch    (ser_latch),
    .addr_strap   (addr_strap),
    .atten_code   (atten_code),
    .frame_reject (frame_reject)
  );

  always @(negedge clk) if (!rst && frame_reject === 1'b1) rej_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic [4:0] hi, input logic [2:0] a,
                                     input logic g, input logic [6:0] c);
    return {hi, a, g, c};
  endfunction

  // Shift n bits (bit 0 first), latch, check code and reject count.
  task automatic run_frame(input logic [31:0] bits, input int n, input logic [6:0] exp,
                           input int exp_rej, input string req);
    int r0;
    for (int i = 0; i < n; i++) begin
      ser_data = bits[i];
      wait_n(HALF);
      ser_clk = 1'b1;
      wait_n(HALF);
      ser_clk = 1'b0;
    end
    wait_n(HALF);
    chk(atten_code == cur_exp, "R6 stable while shifting", atten_code, cur_exp);
    r0 = rej_cnt;
    ser_latch = 1'b1;
    wait_n(5);
    chk(atten_code == exp, req, atten_code, exp);
    ser_latch = 1'b0;
    wait_n(6);
    chk((rej_cnt - r0) == exp_rej, {req, " reject count"}, rej_cnt - r0, exp_rej);
    cur_exp = exp;
  endtask

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(8);
    // R1 reset state
    chk(atten_code == 7'h7F, "R1 reset code", atten_code, 7'h7F);
    chk(frame_reject == 1'b0, "R1 reset reject", frame_reject, 0);

    // R2: every code at one address, high byte junk
    addr_strap = 3'd5;
    for (int c = 0; c < 128; c++) begin
      run_frame({16'h0, mk(5'(c * 7), 3'd5, 1'b0, 7'(c))}, 16, 7'(c), 0, "R2 code sweep");
    end
    // R2: 18.25 dB example -> code 73
    run_frame({16'h0, mk(5'd0, 3'd5, 1'b0, 7'd73)}, 16, 7'd73, 0, "R2 18.25dB");

    // R3/R4: every strap against every frame address
    for (int s = 0; s < 8; s++) begin
      for (int a = 0; a < 8; a++) begin
        logic [6:0] nc;
        nc = 7'((s * 8 + a) ^ 7'h2A);
        addr_strap = 3'(s);
        wait_n(2);
        if (s == a)
          run_frame({16'h0, mk(5'(a * 3 + s), 3'(a), 1'b0, nc)}, 16, nc, 0, "R3 match");
        else
          run_frame({16'h0, mk(5'(a * 3 + s), 3'(a), 1'b0, nc)}, 16, cur_exp, 1, "R4 mismatch");
      end
    end

    // R5: guard bit set on a matching frame
    addr_strap = 3'd2;
    wait_n(2);
    run_frame({16'h0, mk(5'd0, 3'd2, 1'b0, 7'd10)}, 16, 7'd10, 0, "R5 setup");
    run_frame({16'h0, mk(5'd0, 3'd2, 1'b1, 7'd99)}, 16, 7'd10, 1, "R5 guard set");
    run_frame({16'h0, mk(5'h1F, 3'd2, 1'b1, 7'd0)}, 16, 7'd10, 1, "R5 guard set zero code");

    // R7: short frames discarded, then a full one is accepted
    run_frame({16'h0, mk(5'd0, 3'd2, 1'b0, 7'd55)}, 15, 7'd10, 0, "R7 15 bits");
    run_frame({16'h0, mk(5'd0, 3'd2, 1'b0, 7'd55)}, 1, 7'd10, 0, "R7 1 bit");
    run_frame({16'h0, mk(5'd0, 3'd2, 1'b0, 7'd55)}, 16, 7'd55, 0, "R7 full after short");

    // R8: overlong frames keep the last 16 bits
    run_frame({12'h0, mk(5'd0, 3'd2, 1'b0, 7'd21), 4'hF}, 20, 7'd21, 0, "R8 20 bits");
    run_frame({mk(5'd0, 3'd2, 1'b0, 7'd100), mk(5'd0, 3'd6, 1'b1, 7'd1)}, 32, 7'd100, 0,
              "R8 32 bits");

    // R1: maximum code is reachable again and reset restores it
    run_frame({16'h0, mk(5'd0, 3'd2, 1'b0, 7'd0)}, 16, 7'd0, 0, "R2 zero code");
    rst = 1'b1;
    wait_n(3);
    rst = 1'b0;
    wait_n(3);
    chk(atten_code == 7'h7F, "R1 reset again", atten_code, 7'h7F);
    cur_exp = 7'h7F;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule